// File: doc/BRIEF.md
# Status Transition Recorder and Deadtime Counter

This block watches a set of 4-bit throttle status codes: the already filtered per-source inputs of a status merger and the merged outputs that the merger drives. It keeps a free-running 48-bit timestamp that advances once per enabled tick, one tick being one 25 ns unit. Each time any watched channel takes a new code, the block writes a history record holding the timestamp, the channel number and the new code. When several channels move in the same cycle, a small queue drains them into the history memory one per cycle, lowest channel first, and every record keeps the timestamp of the cycle in which its change was seen.

For every channel the block also accumulates two saturating deadtime counts: the number of enabled ticks spent in the Warning code and the number spent in the Busy code. A host reads records, the fill level, the loss status, the counters and the timestamp through a registered read port. Two clear strobes restart the history and restart the time base together with all deadtime counters. The history depth is a parameter. Full hardware uses 131072 entries; the default here is small so that it elaborates quickly.

Top module: `state_trace_unit`

## Requirements
- R1: After reset, the fill level, the overflow flag, the lost count, the timestamp, every deadtime counter and rdData are all zero.
- R2: Channels 0..NUM_IN-1 are the stIn nibbles, with channel c at bits 4c+3:4c. Channels NUM_IN.. are the stOut nibbles in the same way. A code on a channel that differs from its code in the previous cycle produces exactly one history record of that channel and its new code. The first cycle after reset only samples and records nothing.
- R3: The timestamp goes up by one on each clock edge where tsEn is 1 and is otherwise held. A record carries the timestamp value present in the cycle in which its change was seen.
- R4: Changes seen in the same cycle become separate records in ascending channel order, all with the same timestamp. At most one record is written per cycle, at index equal to the fill level, and the fill level then increments.
- R5: If a channel changes again while its earlier change is still waiting and is not being written in that cycle, the waiting change is replaced by the newer one and the lost count increments by one.
- R6: With the fill level equal to HIST_DEPTH, a record due to be written is discarded instead. The overflow flag sets and stays set, the lost count increments, and the fill level stays at HIST_DEPTH.
- R7: A channel's Warning counter increments on each clock edge where tsEn is 1 and the channel's code is 4'h1. This holds for input and output channels alike.
- R8: A channel's Busy counter increments on each clock edge where tsEn is 1 and the channel's code is 4'h4.
- R9: A deadtime counter that reaches all ones stays at all ones instead of wrapping.
- R10: A clock edge with clrTime at 1 zeroes the timestamp and every deadtime counter, and this takes priority over any increment at that edge.
- R11: A clock edge with clrHist at 1 zeroes the fill level, the overflow flag and the lost count. The next record is then written at index 0, and changes still waiting are kept.
- R12: A clock edge with hostRd at 1 loads rdData from hostOp and hostIdx. Otherwise rdData holds. The hostOp codes are: 0 = history record hostIdx, with {timestamp[47:0], channel[3:0], code[3:0]} in bits 55:0; 1 = fill level; 2 = {overflow at bit 16, lost count in bits 15:0}; 3 = Warning counter of channel hostIdx; 4 = Busy counter of channel hostIdx; 5 = timestamp. A channel index at or beyond the channel count reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stIn | input | 4*NUM_IN | Filtered per-source status codes |
| stOut | input | 4*NUM_OUT | Merged output status codes |
| tsEn | input | 1 | One 25 ns tick of the time base |
| hostRd | input | 1 | Read strobe |
| hostOp | input | 3 | Read selector |
| hostIdx | input | 17 | Record index or channel index |
| clrHist | input | 1 | Clear history fill, overflow and lost count |
| clrTime | input | 1 | Clear timestamp and all deadtime counters |
| rdData | output | 64 | Registered read data |

## Verification
Counter accumulation and the time clear can land on the same edge. The bench provokes this by raising clrTime while tsEn is active and a channel sits in Warning, and then expects a zero timestamp and a zero Warning count. A second collision happens inside the history queue, where a channel changes again on the edge that grants another channel's record. The bench forces it by moving all six channels in one cycle and moving the last one again on the next. It expects five records stamped with the first timestamp, a sixth record holding the newer code and timestamp, and a lost count of one.

// File: rtl/stu_pkg.sv
package stu_pkg;
  localparam int ST_W   = 4;
  localparam int TS_W   = 48;
  localparam int CH_W   = 4;
  localparam int IDX_W  = 17;
  localparam int LOST_W = 16;
  localparam int ENT_W  = TS_W + CH_W + ST_W;

  localparam logic [ST_W-1:0] ST_WARN = 4'h1;
  localparam logic [ST_W-1:0] ST_BUSY = 4'h4;

  localparam logic [2:0] OP_ENTRY = 3'd0;
  localparam logic [2:0] OP_FILL  = 3'd1;
  localparam logic [2:0] OP_LOSS  = 3'd2;
  localparam logic [2:0] OP_WARN  = 3'd3;
  localparam logic [2:0] OP_BUSY  = 3'd4;
  localparam logic [2:0] OP_TIME  = 3'd5;

  typedef struct packed {
    logic histWr;
    logic tsClr;
  } strobe_t;
endpackage

// File: rtl/stu_ctrl.sv
module stu_ctrl import stu_pkg::*; #(
  parameter int NCH   = 6,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH*ST_W-1:0]   chState,
  input  logic [TS_W-1:0]       ts,
  input  logic                  clrHist,
  input  logic                  clrTime,
  output strobe_t               strb,
  output logic [AW-1:0]         wrAddr,
  output logic [TS_W-1:0]       wrTs,
  output logic [CH_W-1:0]       wrCh,
  output logic [ST_W-1:0]       wrSt,
  output logic [FW-1:0]         fill,
  output logic                  overflow,
  output logic [LOST_W-1:0]     lost
);
  logic                primed;
  logic [NCH*ST_W-1:0] prevSt;
  logic [NCH-1:0]      chg, pend, grant, overwrite;
  logic [ST_W-1:0]     pSt [NCH];
  logic [TS_W-1:0]     pTs [NCH];
  logic                full, anyGrant, drop;
  logic [LOST_W:0]     lostSum;

  // change detection per channel
  for (genvar c = 0; c < NCH; c++) begin : g_det
    assign chg[c] = primed && (chState[c*ST_W +: ST_W] != prevSt[c*ST_W +: ST_W]);
  end

  // lowest pending channel wins; no grant while the history is being cleared
  assign grant     = clrHist ? '0 : (pend & (~pend + NCH'(1)));
  assign overwrite = chg & pend & ~grant;
  assign anyGrant  = |grant;
  assign full      = (fill == FW'(DEPTH));
  assign drop      = anyGrant && full;

  always_comb begin
    wrCh = '0;
    wrTs = '0;
    wrSt = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        wrCh = CH_W'(i);
        wrTs = pTs[i];
        wrSt = pSt[i];
      end
    end
  end

  assign strb.histWr = anyGrant && !full;
  assign strb.tsClr  = clrTime;
  assign wrAddr      = fill[AW-1:0];
  assign lostSum     = {1'b0, lost} + (LOST_W+1)'(drop) + (LOST_W+1)'($countones(overwrite));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed   <= 1'b0;
      prevSt   <= '0;
      pend     <= '0;
      fill     <= '0;
      overflow <= 1'b0;
      lost     <= '0;
    end else begin
      primed <= 1'b1;
      prevSt <= chState;
      pend   <= (pend & ~grant) | chg;
      if (clrHist) begin
        fill     <= '0;
        overflow <= 1'b0;
        lost     <= '0;
      end else begin
        if (strb.histWr) fill <= fill + FW'(1);
        if (drop) overflow <= 1'b1;
        lost <= lostSum[LOST_W] ? '1 : lostSum[LOST_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (chg[c]) begin
        pSt[c] <= chState[c*ST_W +: ST_W];
        pTs[c] <= ts;
      end
    end
  end

  // R4: the fill level never advances by more than one record per cycle
  a_r4_one_per_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !clrHist |=> (fill == $past(fill)) || (fill == $past(fill) + FW'(1)));

  // R6: fill level bounded by the depth
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FW'(DEPTH));

  // R6: overflow is sticky until a history clear
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !clrHist |=> overflow);

  // R11: history clear empties the loss status and fill level
  a_r11_hist_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrHist |=> (fill == '0) && !overflow && (lost == '0));
endmodule

// File: rtl/stu_dpath.sv
module stu_dpath import stu_pkg::*; #(
  parameter int NCH   = 6,
  parameter int DEPTH = 64,
  parameter int DT_W  = 48,
  localparam int AW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH*ST_W-1:0]   chState,
  input  logic                  tsEn,
  input  strobe_t               strb,
  input  logic [AW-1:0]         wrAddr,
  input  logic [TS_W-1:0]       wrTs,
  input  logic [CH_W-1:0]       wrCh,
  input  logic [ST_W-1:0]       wrSt,
  input  logic [FW-1:0]         fill,
  input  logic                  overflow,
  input  logic [LOST_W-1:0]     lost,
  input  logic                  hostRd,
  input  logic [2:0]            hostOp,
  input  logic [IDX_W-1:0]      hostIdx,
  output logic [TS_W-1:0]       ts,
  output logic [63:0]           rdData
);
  logic [DT_W-1:0]  warnCnt [NCH];
  logic [DT_W-1:0]  busyCnt [NCH];
  logic [NCH-1:0]   warnInc, busyInc;
  logic [ENT_W-1:0] mem [DEPTH];
  logic [DT_W-1:0]  warnSel, busySel;
  logic [63:0]      rdNext;

  for (genvar c = 0; c < NCH; c++) begin : g_inc
    assign warnInc[c] = tsEn && (chState[c*ST_W +: ST_W] == ST_WARN) && (warnCnt[c] != '1);
    assign busyInc[c] = tsEn && (chState[c*ST_W +: ST_W] == ST_BUSY) && (busyCnt[c] != '1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.tsClr) ts <= '0;
    else if (tsEn)           ts <= ts + TS_W'(1);
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rstN || strb.tsClr) begin
        warnCnt[c] <= '0;
        busyCnt[c] <= '0;
      end else begin
        if (warnInc[c]) warnCnt[c] <= warnCnt[c] + DT_W'(1);
        if (busyInc[c]) busyCnt[c] <= busyCnt[c] + DT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.histWr) mem[wrAddr] <= {wrTs, wrCh, wrSt};
  end

  always_comb begin
    warnSel = '0;
    busySel = '0;
    for (int c = 0; c < NCH; c++) begin
      if (hostIdx == IDX_W'(c)) begin
        warnSel = warnCnt[c];
        busySel = busyCnt[c];
      end
    end
  end

  always_comb begin
    case (hostOp)
      OP_ENTRY: rdNext = (hostIdx < IDX_W'(DEPTH)) ? 64'(mem[hostIdx[AW-1:0]]) : '0;
      OP_FILL:  rdNext = 64'(fill);
      OP_LOSS:  rdNext = 64'({overflow, lost});
      OP_WARN:  rdNext = 64'(warnSel);
      OP_BUSY:  rdNext = 64'(busySel);
      OP_TIME:  rdNext = 64'(ts);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)       rdData <= '0;
    else if (hostRd) rdData <= rdNext;
  end

  // R3: timestamp holds without a tick or clear
  a_r3_ts_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tsEn && !strb.tsClr |=> $stable(ts));

  // R10: time clear wins over any increment
  a_r10_time_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.tsClr |=> (ts == '0) && (warnCnt[0] == '0) && (busyCnt[0] == '0));

  // R9: a saturated counter stays saturated
  a_r9_warn_sat: assert property (@(posedge clk) disable iff (!rstN)
    (warnCnt[0] == '1) && !strb.tsClr |=> (warnCnt[0] == '1));

  // R12: read data holds without a read strobe
  a_r12_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> $stable(rdData));
endmodule

// File: rtl/state_trace_unit.sv
module state_trace_unit import stu_pkg::*; #(
  parameter int NUM_IN     = 4,
  parameter int NUM_OUT    = 2,
  parameter int HIST_DEPTH = 64,
  parameter int DT_W       = 48
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IN*ST_W-1:0]    stIn,
  input  logic [NUM_OUT*ST_W-1:0]   stOut,
  input  logic                      tsEn,
  input  logic                      hostRd,
  input  logic [2:0]                hostOp,
  input  logic [IDX_W-1:0]          hostIdx,
  input  logic                      clrHist,
  input  logic                      clrTime,
  output logic [63:0]               rdData
);
  localparam int NCH = NUM_IN + NUM_OUT;
  localparam int AW  = $clog2(HIST_DEPTH);
  localparam int FW  = $clog2(HIST_DEPTH + 1);

  logic [NCH*ST_W-1:0] chState;
  strobe_t             strb;
  logic [AW-1:0]       wrAddr;
  logic [TS_W-1:0]     wrTs, ts;
  logic [CH_W-1:0]     wrCh;
  logic [ST_W-1:0]     wrSt;
  logic [FW-1:0]       fill;
  logic                overflow;
  logic [LOST_W-1:0]   lost;

  assign chState = {stOut, stIn};

  stu_ctrl #(.NCH(NCH), .DEPTH(HIST_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .chState(chState), .ts(ts),
    .clrHist(clrHist), .clrTime(clrTime), .strb(strb),
    .wrAddr(wrAddr), .wrTs(wrTs), .wrCh(wrCh), .wrSt(wrSt),
    .fill(fill), .overflow(overflow), .lost(lost)
  );

  stu_dpath #(.NCH(NCH), .DEPTH(HIST_DEPTH), .DT_W(DT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .chState(chState), .tsEn(tsEn), .strb(strb),
    .wrAddr(wrAddr), .wrTs(wrTs), .wrCh(wrCh), .wrSt(wrSt),
    .fill(fill), .overflow(overflow), .lost(lost),
    .hostRd(hostRd), .hostOp(hostOp), .hostIdx(hostIdx),
    .ts(ts), .rdData(rdData)
  );
endmodule

// File: tb/tb_state_trace_unit.sv
module tb_state_trace_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN  = 4;
  localparam int NUM_OUT = 2;
  localparam int NCH     = NUM_IN + NUM_OUT;
  localparam int DEPTH   = 16;
  localparam int DT_W    = 10;
  localparam int DT_MAX  = (1 << DT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_IN*4-1:0]  stIn = '0;
  logic [NUM_OUT*4-1:0] stOut = '0;
  logic tsEn = 1'b0, hostRd = 1'b0, clrHist = 1'b0, clrTime = 1'b0;
  logic [2:0]  hostOp = '0;
  logic [16:0] hostIdx = '0;
  logic [63:0] rdData;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  // reference model state
  bit        primed = 1'b0;
  logic [3:0] prv [NCH];
  longint    mTs = 0;
  int        mW [NCH];
  int        mB [NCH];
  longint    eTs [64];
  int        eCh [64];
  logic [3:0] eSt [64];
  int        eN = 0;

  state_trace_unit #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .HIST_DEPTH(DEPTH), .DT_W(DT_W)) dut (
    .clk(clk), .rstN(rstN), .stIn(stIn), .stOut(stOut), .tsEn(tsEn),
    .hostRd(hostRd), .hostOp(hostOp), .hostIdx(hostIdx),
    .clrHist(clrHist), .clrTime(clrTime), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] chSt(int c);
    if (c < NUM_IN) return stIn[c*4 +: 4];
    return stOut[(c-NUM_IN)*4 +: 4];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      primed = 1'b0; mTs = 0; eN = 0;
      for (int c = 0; c < NCH; c++) begin mW[c] = 0; mB[c] = 0; end
    end else begin
      if (clrHist) eN = 0;
      for (int c = 0; c < NCH; c++) begin
        if (primed && chSt(c) !== prv[c]) begin
          if (eN < 64) begin eTs[eN] = mTs; eCh[eN] = c; eSt[eN] = chSt(c); end
          eN++;
        end
        prv[c] = chSt(c);
      end
      primed = 1'b1;
      if (clrTime) begin
        mTs = 0;
        for (int c = 0; c < NCH; c++) begin mW[c] = 0; mB[c] = 0; end
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (tsEn && chSt(c) == 4'h1 && mW[c] < DT_MAX) mW[c]++;
          if (tsEn && chSt(c) == 4'h4 && mB[c] < DT_MAX) mB[c]++;
        end
        if (tsEn) mTs++;
      end
    end
  end

  task automatic check(string req, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hostRead(logic [2:0] op, int idx, output logic [63:0] d);
    @(negedge clk);
    hostRd = 1'b1; hostOp = op; hostIdx = 17'(idx);
    @(negedge clk);
    hostRd = 1'b0;
    d = rdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCh(int c, logic [3:0] v);
    if (c < NUM_IN) stIn[c*4 +: 4] = v;
    else stOut[(c-NUM_IN)*4 +: 4] = v;
  endtask

  function automatic logic [3:0] pick();
    case ($urandom % 6)
      0: return 4'h8;
      1: return 4'h1;
      2: return 4'h4;
      3: return 4'h2;
      4: return 4'hC;
      default: return 4'h0;
    endcase
  endfunction

  task automatic pulseClrHist();
    @(negedge clk); clrHist = 1'b1;
    @(negedge clk); clrHist = 1'b0;
  endtask

  task automatic checkHist();
    logic [63:0] d;
    int n;
    n = eN;
    hostRead(3'd1, 0, d);
    check("R4 fill level", longint'(d), longint'(n));
    for (int i = 0; i < n && i < DEPTH; i++) begin
      hostRead(3'd0, i, d);
      check("R2 R3 R4 record", longint'(d[55:0]),
            longint'({eTs[i][47:0], 4'(eCh[i]), eSt[i]}));
    end
  endtask

  task automatic checkCounters();
    logic [63:0] d;
    for (int c = 0; c < NCH; c++) begin
      hostRead(3'd3, c, d);
      check("R7 warn count", longint'(d), longint'(mW[c]));
      hostRead(3'd4, c, d);
      check("R8 busy count", longint'(d), longint'(mB[c]));
    end
    hostRead(3'd5, 0, d);
    check("R3 timestamp", longint'(d), mTs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    longint t0;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) setCh(c, 4'h8);
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData after reset", longint'(rdData), 0);
    hostRead(3'd1, 0, d); check("R1 fill", longint'(d), 0);
    hostRead(3'd2, 0, d); check("R1 loss", longint'(d), 0);
    hostRead(3'd5, 0, d); check("R1 timestamp", longint'(d), 0);
    hostRead(3'd3, 0, d); check("R1 warn", longint'(d), 0);
    hostRead(3'd4, 5, d); check("R1 busy", longint'(d), 0);

    // random rounds
    for (int r = 0; r < 20; r++) begin
      pulseClrHist();
      for (int s = 0; s < 6; s++) begin
        @(negedge clk);
        setCh($urandom % NCH, pick());
        if ($urandom % 2 == 1) setCh($urandom % NCH, pick());
        for (int k = 0; k < 8; k++) begin
          tsEn = 1'($urandom % 2);
          @(negedge clk);
        end
      end
      tsEn = 1'b0;
      idle(8);
      checkHist();
      checkCounters();
    end

    // R4 R5: six same-cycle changes, last channel moves again while waiting
    for (int c = 0; c < NCH; c++) setCh(c, 4'h8);
    tsEn = 1'b0;
    idle(10);
    pulseClrHist();
    hostRead(3'd5, 0, d);
    t0 = longint'(d);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) setCh(c, 4'h2);
    tsEn = 1'b1;
    @(negedge clk);
    setCh(NCH-1, 4'h4);
    tsEn = 1'b0;
    idle(10);
    for (int i = 0; i < NCH-1; i++) begin
      hostRead(3'd0, i, d);
      check("R4 same-cycle order", longint'(d[55:0]), longint'({t0[47:0], 4'(i), 4'h2}));
    end
    hostRead(3'd0, NCH-1, d);
    check("R5 replaced record", longint'(d[55:0]), longint'({48'(t0 + 1), 4'(NCH-1), 4'h4}));
    hostRead(3'd1, 0, d); check("R5 fill", longint'(d), NCH);
    hostRead(3'd2, 0, d); check("R5 lost count", longint'(d), 1);

    // R6: overflow the history
    pulseClrHist();
    hostRead(3'd5, 0, d);
    t0 = longint'(d);
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge clk);
      setCh(0, (i % 2 == 0) ? 4'h1 : 4'h8);
      idle(2);
    end
    idle(4);
    hostRead(3'd1, 0, d); check("R6 fill saturates", longint'(d), DEPTH);
    hostRead(3'd2, 0, d); check("R6 overflow and lost", longint'(d), longint'((1 << 16) | 2));
    hostRead(3'd0, DEPTH-1, d);
    check("R6 last kept record", longint'(d[55:0]), longint'({t0[47:0], 4'd0, 4'h8}));

    // R11: clear history, next record lands at index 0
    pulseClrHist();
    hostRead(3'd1, 0, d); check("R11 fill cleared", longint'(d), 0);
    hostRead(3'd2, 0, d); check("R11 loss cleared", longint'(d), 0);
    @(negedge clk); setCh(3, 4'hC);
    idle(4);
    hostRead(3'd1, 0, d); check("R11 fill after one", longint'(d), 1);
    hostRead(3'd0, 0, d);
    check("R11 record at zero", longint'(d[55:0]), longint'({t0[47:0], 4'd3, 4'hC}));

    // R9: saturation of Warning and Busy counters
    @(negedge clk); clrTime = 1'b1;
    @(negedge clk); clrTime = 1'b0;
    setCh(1, 4'h1); setCh(NUM_IN, 4'h4);
    tsEn = 1'b1;
    idle(DT_MAX + 80);
    tsEn = 1'b0;
    idle(2);
    hostRead(3'd3, 1, d); check("R9 warn saturates", longint'(d), DT_MAX);
    hostRead(3'd4, NUM_IN, d); check("R9 busy saturates", longint'(d), DT_MAX);
    checkCounters();

    // R10: clear at the same edge as an increment
    tsEn = 1'b1;
    idle(5);
    clrTime = 1'b1;
    @(negedge clk);
    clrTime = 1'b0; tsEn = 1'b0;
    hostRead(3'd5, 0, d); check("R10 timestamp cleared", longint'(d), 0);
    hostRead(3'd3, 1, d); check("R10 warn cleared", longint'(d), 0);
    hostRead(3'd4, NUM_IN, d); check("R10 busy cleared", longint'(d), 0);

    // R12: out of range channel, hold without strobe
    hostRead(3'd3, 7, d); check("R12 out of range channel", longint'(d), 0);
    tsEn = 1'b1; idle(3); tsEn = 1'b0;
    hostRead(3'd5, 0, d); check("R12 timestamp read", longint'(d), 3);
    idle(4);
    check("R12 read data holds", longint'(rdData), 3);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule